// File: doc/BRIEF.md
# Indirect Calibration Register Port

This block gives a host bus access to a small internal calibration register file that has no address space of its own. The host writes a target address and a direction flag into one window, the outgoing word into another, then sets a start bit. The block copies the three values at that moment and performs one internal read or write after a fixed latency, with `busy` high while the access is in flight. A read result lands in a read-data window, where the host can fetch it once `busy` has dropped. The host clears the start bit before it launches the next access.

Inside the file, every write except one to the lock word is dropped until the unlock code has been written there. A manual-calibration word holds an enable flag and a delay code. While the flag is set, that code drives the delay-line adjust output. While it is clear, the output follows the automatically measured code, and that code can also be read back at its own internal address. A 2-bit offset, written straight through a host window, drives a separate output. The remaining internal addresses are plain storage words.

Top module: `indirect_cal_port`

## Requirements
- R1: After reset, `busy`, `dly_manual_en` and `dly_offset` are 0, `dly_code` equals `cal_code_in`, and the address/mode window (select 0) and the read-data window (select 3) both read 0.
- R2: A host write to the start window (select 2) launches an access only when data bit 0 is 1, the start bit previously read 0, and `busy` is low. `busy` then stays high for exactly `BUSY_LAT` cycles. Writing 1 again without first writing 0, or writing 1 while `busy` is high, launches nothing.
- R3: The address/mode window (select 0) takes the internal address in bits 5:0, and bit 8 = 1 for a read or 0 for a write. The write-data window is select 1. Once the file is unlocked, a write stores the word at the internal address, and a later read of that address puts the word into the read-data window (select 3) after `busy` falls.
- R4: While the file is locked, which is the state after reset, writes to every internal address other than 0x00 are dropped.
- R5: Writing 0xA5000000 to internal address 0x00 unlocks the file, and writing any other value there locks it again. A read of 0x00 returns the unlock state in bit 0 (1 = unlocked).
- R6: Internal address 0x22 holds the manual enable in bit 7 and the manual code in bits 4:0, and reads back in that layout with all other bits 0. While the enable is 1, `dly_manual_en` is 1 and `dly_code` is the stored code. While it is 0, `dly_code` follows `cal_code_in`. Writing 0 there disables manual mode.
- R7: A read of internal address 0x26 returns `cal_code_in` in bits 4:0 and 0 above. Writes to 0x26 have no effect.
- R8: The offset window (select 4) keeps host data bits 1:0, drives them on `dly_offset` and reads them back, and discards the higher bits.
- R9: Address, direction and write data are copied when the access launches. Rewriting those windows while `busy` is high does not change the access in flight.
- R10: Host writes to the read-data window are ignored. It changes only when an internal read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 3 | Window select: 0 address/mode, 1 write data, 2 start, 3 read data, 4 offset |
| host_wr | input | 1 | Host write strobe for the selected window |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Contents of the selected window |
| cal_code_in | input | CODE_W | Automatically measured calibration code |
| busy | output | 1 | High while an internal access is in flight |
| dly_manual_en | output | 1 | Manual calibration enable |
| dly_code | output | CODE_W | Delay-line adjust code |
| dly_offset | output | OFF_W | Delay-line offset |

## Verification
The bench builds the block with `BUSY_LAT` = 4 rather than the default of 3. This widens the in-flight window enough for the bench to rewrite the address and data windows, and to clear and set the start bit, before the access completes. That makes the capture rule of R9 and the launch refusal of R2 observable. The address and data widths stay at 6 and 32 bits, so the fixed internal addresses of the lock word, the manual word and the measured code, and the unlock code itself, are all exercised as they stand.

// File: rtl/calport_pkg.sv
package calport_pkg;

  typedef enum logic [2:0] {
    WIN_ADDRMODE = 3'd0,
    WIN_WDATA    = 3'd1,
    WIN_START    = 3'd2,
    WIN_RDATA    = 3'd3,
    WIN_OFFSET   = 3'd4
  } win_sel_e;

  localparam int          MODE_RD_BIT  = 8;
  localparam int          MAN_EN_BIT   = 7;
  localparam logic [5:0]  ADDR_LOCK    = 6'h00;
  localparam logic [5:0]  ADDR_MANUAL  = 6'h22;
  localparam logic [5:0]  ADDR_MEAS    = 6'h26;
  localparam logic [31:0] UNLOCK_WORD  = 32'hA500_0000;

endpackage

// File: rtl/cal_host_windows.sv
module cal_host_windows
  import calport_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 32,
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       host_sel,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  input  logic             rd_done,
  input  logic [DW-1:0]    rd_word,
  output logic [AW-1:0]    win_addr,
  output logic             win_rd,
  output logic [DW-1:0]    win_wdata,
  output logic             start_set,
  output logic [OFF_W-1:0] offset
);

  localparam int MODE_PAD = MODE_RD_BIT - AW;
  localparam int HIGH_PAD = DW - MODE_RD_BIT - 1;

  logic [AW-1:0]    addr_q,   addr_d;
  logic             rd_q,     rd_d;
  logic [DW-1:0]    wdata_q,  wdata_d;
  logic             start_q,  start_d;
  logic [DW-1:0]    rdata_q,  rdata_d;
  logic [OFF_W-1:0] off_q,    off_d;

  logic we_mode, we_wdata, we_start, we_off;

  always_comb begin
    we_mode  = host_wr && (host_sel == WIN_ADDRMODE);
    we_wdata = host_wr && (host_sel == WIN_WDATA);
    we_start = host_wr && (host_sel == WIN_START);
    we_off   = host_wr && (host_sel == WIN_OFFSET);

    addr_d  = we_mode  ? host_wdata[AW-1:0]     : addr_q;
    rd_d    = we_mode  ? host_wdata[MODE_RD_BIT] : rd_q;
    wdata_d = we_wdata ? host_wdata             : wdata_q;
    start_d = we_start ? host_wdata[0]          : start_q;
    off_d   = we_off   ? host_wdata[OFF_W-1:0]  : off_q;
    rdata_d = rd_done  ? rd_word                : rdata_q;

    start_set = we_start && host_wdata[0] && !start_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rd_q    <= 1'b0;
      wdata_q <= '0;
      start_q <= 1'b0;
      off_q   <= '0;
      rdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      rd_q    <= rd_d;
      wdata_q <= wdata_d;
      start_q <= start_d;
      off_q   <= off_d;
      rdata_q <= rdata_d;
    end
  end

  always_comb begin
    case (host_sel)
      WIN_ADDRMODE: host_rdata = {{HIGH_PAD{1'b0}}, rd_q, {MODE_PAD{1'b0}}, addr_q};
      WIN_WDATA:    host_rdata = wdata_q;
      WIN_START:    host_rdata = {{(DW-1){1'b0}}, start_q};
      WIN_RDATA:    host_rdata = rdata_q;
      WIN_OFFSET:   host_rdata = {{(DW-OFF_W){1'b0}}, off_q};
      default:      host_rdata = '0;
    endcase
  end

  assign win_addr  = addr_q;
  assign win_rd    = rd_q;
  assign win_wdata = wdata_q;
  assign offset    = off_q;

  // R10
  rdata_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_q) |-> $past(rd_done));

  // R8
  offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_sel == WIN_OFFSET) |=> $stable(off_q));

endmodule

// File: rtl/cal_access_seq.sv
module cal_access_seq #(
  parameter int AW       = 6,
  parameter int DW       = 32,
  parameter int BUSY_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_set,
  input  logic [AW-1:0] win_addr,
  input  logic          win_rd,
  input  logic [DW-1:0] win_wdata,
  output logic          busy,
  output logic          commit,
  output logic [AW-1:0] op_addr,
  output logic          op_rd,
  output logic [DW-1:0] op_wdata
);

  localparam int CW = $clog2(BUSY_LAT + 1);

  logic [CW-1:0] cnt_q,   cnt_d;
  logic [AW-1:0] addr_q,  addr_d;
  logic          rd_q,    rd_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic          launch;

  always_comb begin
    busy   = (cnt_q != '0);
    launch = start_set && !busy;
    commit = (cnt_q == CW'(1));

    if (launch)    cnt_d = CW'(BUSY_LAT);
    else if (busy) cnt_d = cnt_q - CW'(1);
    else           cnt_d = cnt_q;

    addr_d  = launch ? win_addr  : addr_q;
    rd_d    = launch ? win_rd    : rd_q;
    wdata_d = launch ? win_wdata : wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      rd_q    <= rd_d;
      wdata_q <= wdata_d;
    end
  end

  assign op_addr  = addr_q;
  assign op_rd    = rd_q;
  assign op_wdata = wdata_q;

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_set));

  // R2
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(commit));

  // R9
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(wdata_q) && $stable(rd_q)));

endmodule

// File: rtl/cal_reg_file.sv
module cal_reg_file
  import calport_pkg::*;
#(
  parameter int AW     = 6,
  parameter int DW     = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [AW-1:0]     op_addr,
  input  logic              op_rd,
  input  logic [DW-1:0]     op_wdata,
  input  logic [CODE_W-1:0] cal_code_in,
  output logic              rd_done,
  output logic [DW-1:0]     rd_word,
  output logic              dly_manual_en,
  output logic [CODE_W-1:0] dly_code
);

  localparam int DEPTH   = 1 << AW;
  localparam int MAN_PAD = MAN_EN_BIT - CODE_W;

  logic              unlocked_q, unlocked_d;
  logic              man_en_q,   man_en_d;
  logic [CODE_W-1:0] man_val_q,  man_val_d;
  logic              wr_cmd, wr_ok, hit_lock, hit_man;
  logic [DW-1:0]     mem [DEPTH];

  always_comb begin
    wr_cmd   = commit && !op_rd;
    wr_ok    = wr_cmd && unlocked_q;
    hit_lock = (op_addr == AW'(ADDR_LOCK));
    hit_man  = (op_addr == AW'(ADDR_MANUAL));

    unlocked_d = (wr_cmd && hit_lock) ? (op_wdata == UNLOCK_WORD) : unlocked_q;
    man_en_d   = (wr_ok && hit_man) ? op_wdata[MAN_EN_BIT]   : man_en_q;
    man_val_d  = (wr_ok && hit_man) ? op_wdata[CODE_W-1:0]   : man_val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      man_en_q   <= 1'b0;
      man_val_q  <= '0;
    end else begin
      unlocked_q <= unlocked_d;
      man_en_q   <= man_en_d;
      man_val_q  <= man_val_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    if (g == int'(ADDR_LOCK) || g == int'(ADDR_MANUAL) || g == int'(ADDR_MEAS)) begin : g_special
      assign mem[g] = '0;
    end else begin : g_store
      logic          we;
      logic [DW-1:0] word_q;
      assign we = wr_ok && (op_addr == AW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  word_q <= '0;
        else if (we) word_q <= op_wdata;
      end
      assign mem[g] = word_q;
    end
  end

  always_comb begin
    rd_done = commit && op_rd;
    if (op_addr == AW'(ADDR_LOCK))
      rd_word = {{(DW-1){1'b0}}, unlocked_q};
    else if (op_addr == AW'(ADDR_MANUAL))
      rd_word = {{(DW-MAN_EN_BIT-1){1'b0}}, man_en_q, {MAN_PAD{1'b0}}, man_val_q};
    else if (op_addr == AW'(ADDR_MEAS))
      rd_word = {{(DW-CODE_W){1'b0}}, cal_code_in};
    else
      rd_word = mem[op_addr];
  end

  assign dly_manual_en = man_en_q;
  assign dly_code      = man_en_q ? man_val_q : cal_code_in;

  // R4
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !op_rd && !unlocked_q && op_addr == AW'(ADDR_MANUAL))
      |=> ($stable(man_en_q) && $stable(man_val_q)));

  // R5
  unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !op_rd && op_addr == AW'(ADDR_LOCK) && op_wdata == UNLOCK_WORD)
      |=> unlocked_q);

  // R5
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !op_rd && op_addr == AW'(ADDR_LOCK) && op_wdata != UNLOCK_WORD)
      |=> !unlocked_q);

  // R6
  manual_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(man_en_q) |-> $past(commit && !op_rd && op_addr == AW'(ADDR_MANUAL)));

endmodule

// File: rtl/indirect_cal_port.sv
module indirect_cal_port #(
  parameter int AW       = 6,
  parameter int DW       = 32,
  parameter int CODE_W   = 5,
  parameter int OFF_W    = 2,
  parameter int BUSY_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        host_sel,
  input  logic              host_wr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic [CODE_W-1:0] cal_code_in,
  output logic              busy,
  output logic              dly_manual_en,
  output logic [CODE_W-1:0] dly_code,
  output logic [OFF_W-1:0]  dly_offset
);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          rd_done, start_set, win_rd, commit, op_rd;
  logic [DW-1:0] rd_word, win_wdata, op_wdata;
  logic [AW-1:0] win_addr, op_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cal_host_windows #(.AW(AW), .DW(DW), .OFF_W(OFF_W)) u_win (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .rd_done    (rd_done),
    .rd_word    (rd_word),
    .win_addr   (win_addr),
    .win_rd     (win_rd),
    .win_wdata  (win_wdata),
    .start_set  (start_set),
    .offset     (dly_offset)
  );

  cal_access_seq #(.AW(AW), .DW(DW), .BUSY_LAT(BUSY_LAT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_set (start_set),
    .win_addr  (win_addr),
    .win_rd    (win_rd),
    .win_wdata (win_wdata),
    .busy      (busy),
    .commit    (commit),
    .op_addr   (op_addr),
    .op_rd     (op_rd),
    .op_wdata  (op_wdata)
  );

  cal_reg_file #(.AW(AW), .DW(DW), .CODE_W(CODE_W)) u_file (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .commit        (commit),
    .op_addr       (op_addr),
    .op_rd         (op_rd),
    .op_wdata      (op_wdata),
    .cal_code_in   (cal_code_in),
    .rd_done       (rd_done),
    .rd_word       (rd_word),
    .dly_manual_en (dly_manual_en),
    .dly_code      (dly_code)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_int_n |=> (!busy || !rst_int_n));

endmodule

// File: tb/tb_indirect_cal_port.sv
module tb_indirect_cal_port;
  import calport_pkg::*;

  localparam int AW = 6, DW = 32, CODE_W = 5, OFF_W = 2, LAT = 4;

  logic              clk, rst_n, host_wr;
  logic [2:0]        host_sel;
  logic [DW-1:0]     host_wdata, host_rdata;
  logic [CODE_W-1:0] cal_code_in, dly_code;
  logic              busy, dly_manual_en;
  logic [OFF_W-1:0]  dly_offset;

  int n_tests = 0, n_fail = 0;
  bit done = 0, chk_req = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  indirect_cal_port #(.AW(AW), .DW(DW), .CODE_W(CODE_W), .OFF_W(OFF_W), .BUSY_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cal_code_in(cal_code_in),
    .busy(busy), .dly_manual_en(dly_manual_en), .dly_code(dly_code), .dly_offset(dly_offset)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(logic [2:0] sel, logic [31:0] data);
    @(negedge clk);
    host_sel = sel; host_wdata = data; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic access(logic [5:0] addr, bit rd, logic [31:0] data);
    hw(WIN_WDATA, data);
    hw(WIN_ADDRMODE, {23'd0, rd, 2'b00, addr});
    hw(WIN_START, 32'd1);
    while (busy) @(negedge clk);
    hw(WIN_START, 32'd0);
  endtask

  // scoreboard driver: push expected read result, monitor compares
  task automatic rd_expect(logic [5:0] addr, logic [31:0] exp, string tag);
    access(addr, 1'b1, 32'd0);
    host_sel = WIN_RDATA;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    chk_req = 1;
    wait (chk_req == 0);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (chk_req && exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, host_rdata, e);
        chk_req = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : driver
    int n;
    rst_n = 0; host_wr = 0; host_sel = WIN_ADDRMODE; host_wdata = '0;
    cal_code_in = 5'h0B;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 manual_en", {31'd0, dly_manual_en}, 0);
    check("R1 offset", {30'd0, dly_offset}, 0);
    check("R1 code follows input", {27'd0, dly_code}, 32'h0B);
    check("R1 addrmode window", host_rdata, 0);
    host_sel = WIN_RDATA; #0;
    @(negedge clk);
    check("R1 rdata window", host_rdata, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R4 locked: writes dropped
    access(6'h05, 1'b0, 32'h1111_2222);
    rd_expect(6'h05, 32'h0, "R4 locked scratch write dropped");
    access(6'h22, 1'b0, 32'h0000_009F);
    check("R4 locked manual write dropped", {31'd0, dly_manual_en}, 0);
    rd_expect(6'h00, 32'h0, "R5 lock state reads 0");

    // R5 unlock
    access(6'h00, 1'b0, 32'hA500_0000);
    rd_expect(6'h00, 32'h1, "R5 unlock state reads 1");

    // R3 write / read back
    access(6'h05, 1'b0, 32'hDEAD_BEEF);
    rd_expect(6'h05, 32'hDEAD_BEEF, "R3 readback 0x05");
    access(6'h3F, 1'b0, 32'h1234_5678);
    rd_expect(6'h3F, 32'h1234_5678, "R3 readback 0x3F");

    // R2 busy length
    hw(WIN_ADDRMODE, 32'h0000_0105);
    hw(WIN_START, 32'd1);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    check("R2 busy length", n, LAT);
    // R2 rewrite 1 without clearing: no launch
    hw(WIN_START, 32'd1);
    n = 0;
    repeat (6) begin if (busy) n++; @(negedge clk); end
    check("R2 repeated set no launch", n, 0);
    hw(WIN_START, 32'd0);

    // R2 start while busy ignored
    hw(WIN_WDATA, 32'hCAFE_0001);
    hw(WIN_ADDRMODE, 32'h0000_0009);
    hw(WIN_START, 32'd1);
    hw(WIN_START, 32'd0);
    hw(WIN_START, 32'd1);
    while (busy) @(negedge clk);
    n = 0;
    repeat (6) begin if (busy) n++; @(negedge clk); end
    check("R2 set while busy no launch", n, 0);
    hw(WIN_START, 32'd0);

    // R9 capture at launch
    hw(WIN_WDATA, 32'hAAAA_0007);
    hw(WIN_ADDRMODE, 32'h0000_0007);
    hw(WIN_START, 32'd1);
    hw(WIN_WDATA, 32'hBBBB_0008);
    hw(WIN_ADDRMODE, 32'h0000_0008);
    while (busy) @(negedge clk);
    hw(WIN_START, 32'd0);
    rd_expect(6'h07, 32'hAAAA_0007, "R9 captured addr/data");
    rd_expect(6'h08, 32'h0, "R9 later window value unused");

    // R6 manual calibration
    access(6'h22, 1'b0, 32'h0000_00F3);
    check("R6 manual_en", {31'd0, dly_manual_en}, 1);
    check("R6 manual code", {27'd0, dly_code}, 32'h13);
    cal_code_in = 5'h1C;
    @(negedge clk);
    check("R6 code holds manual value", {27'd0, dly_code}, 32'h13);
    rd_expect(6'h22, 32'h0000_0093, "R6 manual readback layout");
    access(6'h22, 1'b0, 32'h0);
    check("R6 manual disabled", {31'd0, dly_manual_en}, 0);
    check("R6 code follows input", {27'd0, dly_code}, 32'h1C);

    // R7 measured code
    cal_code_in = 5'h0B;
    rd_expect(6'h26, 32'h0000_000B, "R7 measured code read");
    access(6'h26, 1'b0, 32'hFFFF_FFFF);
    rd_expect(6'h26, 32'h0000_000B, "R7 write ignored");

    // R8 offset window
    hw(WIN_OFFSET, 32'hFFFF_FFFE);
    check("R8 dly_offset", {30'd0, dly_offset}, 2);
    host_sel = WIN_OFFSET;
    @(negedge clk);
    check("R8 offset readback", host_rdata, 32'h2);

    // R10 rdata window write ignored
    hw(WIN_RDATA, 32'h5555_5555);
    host_sel = WIN_RDATA;
    @(negedge clk);
    check("R10 rdata write ignored", host_rdata, 32'h0000_000B);

    // R5 relock
    access(6'h00, 1'b0, 32'h0000_0001);
    rd_expect(6'h00, 32'h0, "R5 relocked");
    access(6'h05, 1'b0, 32'h0BAD_0BAD);
    rd_expect(6'h05, 32'hDEAD_BEEF, "R4 relocked write dropped");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule